// File: doc/BRIEF.md
# Instruction Fetch Unit with Prefetch Buffer

This block is the front end of a three-stage fetch, decode and execute pipeline for a 32-bit processor. It keeps a fetch program counter, issues word-aligned instruction reads to a memory whose response time is not fixed, and hands each returned word, tagged with its address, to decode over a valid/ready handshake. With no stalls and a one-cycle memory, it delivers one word per cycle. Two instructions then finish in four cycles rather than the six that unpipelined execution would take.

When execute is busy with a multi-cycle instruction, decode holds and stops accepting words. The fetch unit keeps reading ahead into a small queue during that time. The next word is already waiting when the stall clears, so the memory latency is spent during the stall and is not added after it. A redirect from execute empties the queue, marks every read still in flight as stale, and restarts fetching at the new target.

Top module: `ifetch_prefetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_valid` is low. The first read request is issued at address 0.
- R2: Every request address has its two low bits at zero. Each granted request moves the fetch address forward by 4. A request that has not been granted stays asserted with the same address until it is granted, unless a redirect arrives.
- R3: Words reach decode in program order. Each word's `dec_pc` is 4 above that of the word before it, and `dec_instr` is the memory data read at `dec_pc`.
- R4: While `dec_valid` is high and `dec_ready` is low, with no redirect, `dec_valid`, `dec_pc` and `dec_instr` stay unchanged into the next cycle.
- R5: Fetching continues while decode is stalled. A request is raised whenever the number of buffered words plus the number of live reads is less than DEPTH (default 2), plus one if decode takes a word in that cycle. `dec_valid` is high whenever at least one word is buffered and no redirect is present.
- R6: With a one-cycle memory, a grant in every cycle and decode always ready, one word is delivered per cycle after a fill time of two cycles.
- R7: In a cycle with `redir_valid` high, `dec_valid` and `mem_req` are both low. The buffered words are dropped. The next request and the next delivered word use `redir_addr` with its low two bits forced to 0.
- R8: Responses to reads granted before a redirect are discarded and never reach decode.
- R9: Live reads plus stale reads still in flight never exceed MAX_OUT (default 4). No request is raised while the total is at that limit.
- R10: Read data may return any number of cycles (one or more) after the grant, in request order, and the results still meet R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Instruction read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data |
| redir_valid | input | 1 | Branch redirect from execute |
| redir_addr | input | 32 | Redirect target address |
| dec_valid | output | 1 | Instruction word available to decode |
| dec_instr | output | 32 | Instruction word |
| dec_pc | output | 32 | Address of the instruction word |
| dec_ready | input | 1 | Decode takes the word this cycle |

## Verification
The critical coincidence is a redirect landing in the same cycle as a memory response or a decode stall. A late response then has to be dropped rather than buffered, and the stalled word has to be flushed rather than held. The bench sweeps memory latency, grant gaps and decode stall patterns against a redirect that arrives every 23 cycles, so redirects fall on every phase of the in-flight reads. It judges each cycle against a model of buffer occupancy and live and stale reads, and it checks every delivered word's address and data against the expected program order.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        word_t pc;
        word_t instr;
    } fetch_entry_t;
endpackage

// File: rtl/ifp_queue.sv
module ifp_queue
    import ifp_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  fetch_entry_t push_data,
    input  logic         pop,
    output fetch_entry_t head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        fetch_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t q_q, q_d;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (push) begin
                q_d.slot[q_q.wr] = push_data;
                q_d.wr           = step_ptr(q_q.wr);
            end
            if (pop) begin
                q_d.rd = step_ptr(q_q.rd);
            end
            q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.slot[q_q.rd];
    assign count = q_q.cnt;
endmodule

// File: rtl/ifp_track.sv
module ifp_track #(
    parameter int MAX_OUT = 4,
    localparam int OW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_fire,
    input  logic          rvalid,
    input  logic          redirect,
    output logic          keep,
    output logic [OW-1:0] live,
    output logic [OW-1:0] stale
);
    typedef struct packed {
        logic [OW-1:0] live;
        logic [OW-1:0] stale;
    } trk_state_t;

    trk_state_t t_q, t_d;
    logic       drop;

    always_comb begin
        drop = rvalid && (t_q.stale != '0);
        keep = rvalid && (t_q.stale == '0);
        t_d.live  = t_q.live + OW'(gnt_fire) - OW'(keep);
        t_d.stale = t_q.stale - OW'(drop);
        if (redirect) begin
            t_d.stale = t_d.stale + t_d.live;
            t_d.live  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign live  = t_q.live;
    assign stale = t_q.stale;
endmodule

// File: rtl/ifp_pc.sv
module ifp_pc
    import ifp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  gnt_fire,
    input  logic  push,
    input  logic  redirect,
    input  word_t target,
    output word_t fetch_pc,
    output word_t resp_pc
);
    typedef struct packed {
        word_t fpc;
        word_t rpc;
    } pc_state_t;

    pc_state_t p_q, p_d;
    word_t     aligned;

    always_comb begin
        aligned = target & ~word_t'(3);
        p_d     = p_q;
        if (redirect) begin
            p_d.fpc = aligned;
            p_d.rpc = aligned;
        end else begin
            if (gnt_fire) p_d.fpc = p_q.fpc + word_t'(4);
            if (push)     p_d.rpc = p_q.rpc + word_t'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign fetch_pc = p_q.fpc;
    assign resp_pc  = p_q.rpc;
endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
    import ifp_pkg::*;
#(
    parameter int DEPTH   = 2,
    parameter int MAX_OUT = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int OW = $clog2(MAX_OUT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        redir_valid,
    input  logic [31:0] redir_addr,
    output logic        dec_valid,
    output logic [31:0] dec_instr,
    output logic [31:0] dec_pc,
    input  logic        dec_ready
);
    logic          gnt_fire, keep, push, pop;
    logic [OW-1:0] live, stale;
    logic [CW-1:0] occ;
    word_t         fetch_pc, resp_pc;
    fetch_entry_t  head, in_entry;

    always_comb begin
        dec_valid = (occ != '0) && !redir_valid;
        pop       = dec_valid && dec_ready;
        mem_req   = !redir_valid
                 && ((int'(occ) + int'(live)) < (DEPTH + int'(pop)))
                 && ((int'(live) + int'(stale)) < MAX_OUT);
        gnt_fire  = mem_req && mem_gnt;
        push      = keep && !redir_valid;
        in_entry  = '{pc: resp_pc, instr: mem_rdata};
    end

    assign mem_addr  = fetch_pc;
    assign dec_instr = head.instr;
    assign dec_pc    = head.pc;

    ifp_pc u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt_fire (gnt_fire),
        .push     (push),
        .redirect (redir_valid),
        .target   (redir_addr),
        .fetch_pc (fetch_pc),
        .resp_pc  (resp_pc)
    );

    ifp_track #(.MAX_OUT(MAX_OUT)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt_fire (gnt_fire),
        .rvalid   (mem_rvalid),
        .redirect (redir_valid),
        .keep     (keep),
        .live     (live),
        .stale    (stale)
    );

    ifp_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid),
        .push      (push),
        .push_data (in_entry),
        .pop       (pop),
        .head      (head),
        .count     (occ)
    );
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_gnt,
    input logic        redir_valid,
    input logic        dec_valid,
    input logic [31:0] dec_instr,
    input logic [31:0] dec_pc,
    input logic        dec_ready
);
    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !dec_valid); // R1

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (redir_valid || (mem_req && $stable(mem_addr)))); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready) |=> (!dec_valid || redir_valid || (dec_pc == $past(dec_pc) + 32'd4))); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (redir_valid || (dec_valid && $stable(dec_pc) && $stable(dec_instr)))); // R4

    AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (!dec_valid && !mem_req)); // R7
endmodule

bind ifetch_prefetch ifp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .redir_valid (redir_valid),
    .dec_valid   (dec_valid),
    .dec_instr   (dec_instr),
    .dec_pc      (dec_pc),
    .dec_ready   (dec_ready)
);

// File: tb/ifetch_prefetch_bench.sv
module ifetch_prefetch_bench;
    localparam int DEPTH   = 2;
    localparam int MAX_OUT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_addr = '0;
    logic        dec_valid, dec_ready = 1'b0;
    logic [31:0] dec_instr, dec_pc;

    int total = 0, bad = 0, cyc = 0, hs = 0;
    bit finished = 0;

    // bench model
    int          occ = 0, live = 0, stale = 0, npend = 0, last_rdy = 0;
    logic [31:0] exp_fpc = 0, exp_dpc = 0;
    logic [31:0] p_addr [16];
    int          p_rdy  [16];
    bit          p_stale[16];
    bit          held = 0;
    logic [31:0] held_pc = 0;

    always #2.5 clk = ~clk;

    ifetch_prefetch #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_ifetch_prefetch (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc),
        .dec_ready(dec_ready)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input bit redir, input logic [31:0] raddr, input bit rdy, input bit gnt, input int lat);
        bit exp_valid, exp_req, pop_now;
        @(negedge clk);
        cyc++;
        redir_valid = redir;
        redir_addr  = raddr;
        dec_ready   = rdy;
        mem_gnt     = gnt;
        if (npend > 0 && p_rdy[0] <= cyc) begin
            mem_rvalid = 1'b1;
            mem_rdata  = word_at(p_addr[0]);
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = 32'hDEAD_BEEF;
        end
        #1;
        exp_valid = (occ > 0) && !redir;
        pop_now   = exp_valid && rdy;
        exp_req   = !redir && (occ + live < DEPTH + int'(pop_now)) && (live + stale < MAX_OUT);
        check(dec_valid == exp_valid, redir ? "R7 dec_valid" : "R5 dec_valid", 32'(dec_valid), 32'(exp_valid));
        check(mem_req == exp_req, redir ? "R7 mem_req" : "R5 R9 mem_req", 32'(mem_req), 32'(exp_req));
        if (mem_req) check(mem_addr == exp_fpc, "R2 mem_addr", mem_addr, exp_fpc);
        if (held && dec_valid) check(dec_pc == held_pc, "R4 stall hold", dec_pc, held_pc);
        held = dec_valid && !rdy;
        held_pc = dec_pc;
        if (dec_valid && rdy) begin
            check(dec_pc == exp_dpc, lat > 1 ? "R10 R8 dec_pc" : "R3 R8 dec_pc", dec_pc, exp_dpc);
            check(dec_instr == word_at(exp_dpc), "R3 dec_instr", dec_instr, word_at(exp_dpc));
            exp_dpc += 4;
            occ--;
            hs++;
        end
        if (mem_rvalid) begin
            if (p_stale[0]) stale--;
            else begin
                live--;
                if (!redir) occ++;
            end
            for (int i = 0; i < 15; i++) begin
                p_addr[i] = p_addr[i+1]; p_rdy[i] = p_rdy[i+1]; p_stale[i] = p_stale[i+1];
            end
            npend--;
        end
        if (mem_req && gnt) begin
            p_addr[npend]  = mem_addr;
            p_rdy[npend]   = (cyc + lat > last_rdy + 1) ? cyc + lat : last_rdy + 1;
            last_rdy       = p_rdy[npend];
            p_stale[npend] = 0;
            npend++;
            live++;
            exp_fpc += 4;
        end
        if (redir) begin
            for (int i = 0; i < npend; i++) p_stale[i] = 1;
            stale += live;
            live = 0;
            occ  = 0;
            held = 0;
            exp_fpc = raddr & ~32'd3;
            exp_dpc = raddr & ~32'd3;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(dec_valid == 1'b0, "R1 dec_valid", 32'(dec_valid), 0);
        check(mem_req == 1'b1, "R1 mem_req", 32'(mem_req), 1);
        check(mem_addr == 32'd0, "R1 mem_addr", mem_addr, 0);
        cyc = 0;
        // R6: streaming throughput, one-cycle memory
        hs = 0;
        for (int k = 0; k < 30; k++) step(0, 0, 1, 1, 1);
        check(hs >= 28, "R6 throughput", hs, 28);
        // R5: prefetch fills buffer during decode stall, then resumes at once
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 3);
        check(occ == DEPTH, "R5 buffer filled", occ, DEPTH);
        check(dec_valid == 1'b1, "R5 word ready", 32'(dec_valid), 1);
        // sweep: latency x decode pattern x grant pattern, periodic redirects
        for (int lat = 1; lat <= 4; lat++)
            for (int rm = 0; rm < 3; rm++)
                for (int gm = 0; gm < 3; gm++)
                    for (int k = 0; k < 150; k++) begin
                        bit r, g, d;
                        d = (rm == 0) ? 1 : (rm == 1) ? (k % 3 != 0) : ((k / 5) % 2 == 1);
                        g = (gm == 0) ? 1 : (gm == 1) ? (k % 2 == 0) : (k % 4 != 3);
                        r = (k % 23 == 22) || (k % 37 == lat);
                        step(r, 32'h1000 + 32'(k * 64 + lat * 8 + rm * 4 + gm) + 32'd3, d, g, lat);
                    end
        // drain
        for (int k = 0; k < 20; k++) step(0, 0, 1, 1, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule